// File: doc/BRIEF.md
# Byte-Wide Boot Configuration Loader

After reset this block copies a fixed window of an external 8-bit parallel non-volatile memory into a bank of sixteen 32-bit configuration words. It drives a 16-bit address bus and an active-low read strobe. It takes each data byte as the strobe returns high and merges four consecutive bytes into one word, with the lowest address in the least significant byte. The window covers byte addresses 0x0040 to 0x007F. A memory of 128 bytes therefore holds the whole window, and the 16-bit address reaches at most 64K bytes.

A strap input says which kind of boot memory is fitted. When the strap is low, a byte-wide device is present and the preload runs. When it is high, a serial device or no device is fitted, and the loader stays idle with both strobes high. Once the preload completes, a simple request port writes single bytes back to the memory. Each write uses an active-low write strobe of fixed width and ends with a one-cycle acknowledge. The configuration words can be read at any time through an index port.

Top module: `nvbyte_cfg_loader`

## Requirements
- R1: While reset is asserted, and until the first read strobe, mem_rd_n and mem_wr_n are high, busy, done and wr_ack are low, and every configuration word reads as zero.
- R2: The strap is examined only while the loader is idle. With strap_serial high, no read strobe is issued, busy and done stay low, and wr_req is ignored (no write strobe, no acknowledge).
- R3: With strap_serial low, the loader issues exactly one read strobe per byte address from 0x0040 up to 0x007F, in ascending order, 64 strobes in all.
- R4: Each read strobe stays low for exactly RD_LOW_CYC clock cycles. mem_addr is stable throughout the low time and for the one cycle after the strobe returns high.
- R5: The byte stored for an address is the value on mem_rdata in the last clock cycle before mem_rd_n rises.
- R6: Byte address A in the window lands in word index (A-0x0040)/4, at bits 8*((A-0x0040) mod 4)+7 down to 8*((A-0x0040) mod 4). cfg_rd_word shows the word selected by cfg_rd_idx in the same cycle.
- R7: busy is high from the first read strobe through the cycle after the last one. done rises when busy falls and stays high until the next reset. busy and done are never high together.
- R8: A wr_req that arrives while busy is high is dropped. It causes no write strobe, either during the preload or afterwards.
- R9: An accepted write holds mem_wr_n low for exactly WR_LOW_CYC cycles. For the whole of that time mem_addr and mem_wdata equal the wr_addr and wr_data sampled with the request.
- R10: wr_ack is high for exactly one cycle, the cycle in which mem_wr_n has just returned high. wr_req is sampled only when done is high and no write is in progress, so a request held during a write starts no second write.
- R11: mem_rd_n and mem_wr_n are never low in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_serial | input | 1 | High: serial device or no device, so the loader stays idle. Low: a byte-wide device is present |
| mem_addr | output | 16 | Address to the external memory |
| mem_rd_n | output | 1 | Active-low read strobe |
| mem_wr_n | output | 1 | Active-low write strobe |
| mem_wdata | output | 8 | Byte presented during a write |
| mem_rdata | input | 8 | Byte returned by the memory |
| wr_req | input | 1 | Write request, sampled each cycle while the loader is ready |
| wr_addr | input | 16 | Byte address of the requested write |
| wr_data | input | 8 | Byte value of the requested write |
| wr_ack | output | 1 | One-cycle completion pulse for a write |
| busy | output | 1 | Preload in progress |
| done | output | 1 | Preload complete, writes accepted |
| cfg_rd_idx | input | 4 | Index of the configuration word to show |
| cfg_rd_word | output | 32 | Selected configuration word |

## Verification
The bench builds the block with RD_LOW_CYC = 3 and WR_LOW_CYC = 5 instead of the default 4 and 4. With two different widths, a design that swaps the read and write lengths, or that ignores either parameter, produces a pulse of the wrong length. The shorter read strobe also brings the full 64-byte preload into a few hundred cycles. The memory model drives data only while the read strobe is low, so a byte taken after the strobe rises reads as zero and shows up in the packed words.

// File: rtl/nvbyte_pkg.sv
package nvbyte_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_RD_LOW  = 3'd1,
    ST_RD_HOLD = 3'd2,
    ST_READY   = 3'd3,
    ST_WR_LOW  = 3'd4,
    ST_WR_ACK  = 3'd5
  } ldr_state_e;

  localparam int unsigned BYTES_PER_WORD = 4;

endpackage

// File: rtl/nvbyte_pulse_timer.sv
// Counts the low time of a strobe; 'last' marks its final cycle.
module nvbyte_pulse_timer #(
  parameter int unsigned CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] len_m1,
  output logic          last
);

  logic [CW-1:0] cnt_q, cnt_d;

  assign last = run && (cnt_q == len_m1);

  always_comb begin
    cnt_d = cnt_q;
    if (!run || last) cnt_d = '0;
    else              cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4 / R9: a strobe that has not reached its last cycle keeps running
  assert_pulse_continues_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !last) |=> run);

  // R4 / R9: count never passes the programmed length while running
  assert_count_bounded_R9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= len_m1));

endmodule

// File: rtl/nvbyte_word_bank.sv
// Bank of configuration words written one byte lane at a time.
module nvbyte_word_bank #(
  parameter int unsigned NUM_WORDS = 16,
  parameter int unsigned IDX_W     = $clog2(NUM_WORDS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [1:0]       lane,
  input  logic [7:0]       din,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [31:0]      rd_word
);

  import nvbyte_pkg::*;

  localparam int unsigned NLANE = NUM_WORDS * BYTES_PER_WORD;

  logic [31:0]      word_v [NUM_WORDS];
  logic [NLANE-1:0] lane_we;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    logic [31:0] word_q, word_d;

    for (genvar l = 0; l < BYTES_PER_WORD; l++) begin : g_lane
      assign lane_we[w*BYTES_PER_WORD + l] =
        we && (wr_idx == IDX_W'(w)) && (lane == 2'(l));
    end

    always_comb begin
      word_d = word_q;
      for (int l = 0; l < BYTES_PER_WORD; l++) begin
        if (lane_we[w*BYTES_PER_WORD + l]) word_d[8*l +: 8] = din;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) word_q <= '0;
      else        word_q <= word_d;
    end

    assign word_v[w] = word_q;
  end

  assign rd_word = word_v[rd_idx];

  // R6: a captured byte goes to one lane of one word only
  assert_single_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_we));

  // R6: a capture always reaches some lane
  assert_capture_lands_R6: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> ($countones(lane_we) == 1));

endmodule

// File: rtl/nvbyte_cfg_loader.sv
module nvbyte_cfg_loader #(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned WIN_BASE   = 'h40,
  parameter int unsigned NUM_WORDS  = 16,
  parameter int unsigned RD_LOW_CYC = 4,
  parameter int unsigned WR_LOW_CYC = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        strap_serial,
  output logic [15:0] mem_addr,
  output logic        mem_rd_n,
  output logic        mem_wr_n,
  output logic [7:0]  mem_wdata,
  input  logic [7:0]  mem_rdata,
  input  logic        wr_req,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_data,
  output logic        wr_ack,
  output logic        busy,
  output logic        done,
  input  logic [3:0]  cfg_rd_idx,
  output logic [31:0] cfg_rd_word
);

  import nvbyte_pkg::*;

  localparam int unsigned IDX_W     = $clog2(NUM_WORDS);
  localparam int unsigned OFF_W     = IDX_W + 2;
  localparam int unsigned WIN_BYTES = NUM_WORDS * BYTES_PER_WORD;
  localparam int unsigned MAX_LOW   = (RD_LOW_CYC > WR_LOW_CYC) ? RD_LOW_CYC : WR_LOW_CYC;
  localparam int unsigned CW        = $clog2(MAX_LOW + 1);
  localparam logic [ADDR_W-1:0] WIN_FIRST = ADDR_W'(WIN_BASE);
  localparam logic [ADDR_W-1:0] WIN_LAST  = ADDR_W'(WIN_BASE + WIN_BYTES - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s_n = rst_sync_q[1];

  ldr_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [7:0]        wdat_q, wdat_d;
  logic              tmr_run, tmr_last;
  logic [CW-1:0]     tmr_len_m1;
  logic [OFF_W-1:0]  byte_off;
  logic              cap_we;

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    wdat_d = wdat_q;
    unique case (st_q)
      ST_IDLE: begin
        if (!strap_serial) begin
          st_d   = ST_RD_LOW;
          addr_d = WIN_FIRST;
        end
      end
      ST_RD_LOW:  if (tmr_last) st_d = ST_RD_HOLD;
      ST_RD_HOLD: begin
        if (addr_q == WIN_LAST) begin
          st_d = ST_READY;
        end else begin
          st_d   = ST_RD_LOW;
          addr_d = addr_q + 1'b1;
        end
      end
      ST_READY: begin
        if (wr_req) begin
          st_d   = ST_WR_LOW;
          addr_d = ADDR_W'(wr_addr);
          wdat_d = wr_data;
        end
      end
      ST_WR_LOW: if (tmr_last) st_d = ST_WR_ACK;
      ST_WR_ACK: st_d = ST_READY;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      wdat_q <= '0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      wdat_q <= wdat_d;
    end
  end

  assign tmr_run    = (st_q == ST_RD_LOW) || (st_q == ST_WR_LOW);
  assign tmr_len_m1 = (st_q == ST_RD_LOW) ? CW'(RD_LOW_CYC - 1) : CW'(WR_LOW_CYC - 1);

  nvbyte_pulse_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_s_n),
    .run    (tmr_run),
    .len_m1 (tmr_len_m1),
    .last   (tmr_last)
  );

  // byte is taken on the edge at which the read strobe rises
  assign cap_we   = (st_q == ST_RD_LOW) && tmr_last;
  assign byte_off = OFF_W'(addr_q - WIN_FIRST);

  nvbyte_word_bank #(.NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .we      (cap_we),
    .wr_idx  (byte_off[OFF_W-1:2]),
    .lane    (byte_off[1:0]),
    .din     (mem_rdata),
    .rd_idx  (IDX_W'(cfg_rd_idx)),
    .rd_word (cfg_rd_word)
  );

  assign mem_addr  = 16'(addr_q);
  assign mem_wdata = wdat_q;
  assign mem_rd_n  = (st_q != ST_RD_LOW);
  assign mem_wr_n  = (st_q != ST_WR_LOW);
  assign wr_ack    = (st_q == ST_WR_ACK);
  assign busy      = (st_q == ST_RD_LOW) || (st_q == ST_RD_HOLD);
  assign done      = (st_q == ST_READY) || (st_q == ST_WR_LOW) || (st_q == ST_WR_ACK);

  // R2: idle with serial strap issues no read
  assert_serial_idle_R2: assert property (@(posedge clk) disable iff (!rst_s_n)
    (st_q == ST_IDLE && strap_serial) |=> (mem_rd_n && !busy));

  // R4: address held for the cycle in which the read strobe rises
  assert_addr_hold_R4: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(mem_rd_n) |-> $stable(mem_addr));

  // R7: busy ends only into done, and done is sticky
  assert_busy_to_done_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(busy) |-> done);
  assert_done_sticky_R7: assert property (@(posedge clk) disable iff (!rst_s_n)
    done |=> done);

  // R8: no write strobe during preload
  assert_no_write_busy_R8: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy |-> mem_wr_n);

  // R9: address and data steady while the write strobe is low
  assert_wr_stable_R9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!mem_wr_n && $past(!mem_wr_n)) |-> ($stable(mem_addr) && $stable(mem_wdata)));

  // R10: acknowledge is one cycle and follows a write strobe
  assert_ack_pulse_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_ack |=> !wr_ack);
  assert_ack_after_wr_R10: assert property (@(posedge clk) disable iff (!rst_s_n)
    wr_ack |-> $past(!mem_wr_n));

  // R11: strobes mutually exclusive
  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_s_n)
    !(!mem_rd_n && !mem_wr_n));

endmodule

// File: tb/nvbyte_cfg_loader_bench.sv
module nvbyte_cfg_loader_bench;

  localparam int RD_N = 3;
  localparam int WR_N = 5;

  logic        clk = 1'b0;
  logic        rst_n, strap_serial;
  logic [15:0] mem_addr;
  logic        mem_rd_n, mem_wr_n;
  logic [7:0]  mem_wdata, mem_rdata;
  logic        wr_req;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic        wr_ack, busy, done;
  logic [3:0]  cfg_rd_idx;
  logic [31:0] cfg_rd_word;

  always #5 clk = ~clk;

  nvbyte_cfg_loader #(.RD_LOW_CYC(RD_N), .WR_LOW_CYC(WR_N)) u_nvbyte_cfg_loader (
    .clk(clk), .rst_n(rst_n), .strap_serial(strap_serial),
    .mem_addr(mem_addr), .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ack(wr_ack),
    .busy(busy), .done(done), .cfg_rd_idx(cfg_rd_idx), .cfg_rd_word(cfg_rd_word)
  );

  function automatic logic [7:0] fmem(input logic [15:0] a);
    return (a[7:0] * 8'd29 + 8'h3C) ^ a[15:8];
  endfunction

  // memory model drives data only while the read strobe is low (R5)
  assign mem_rdata = mem_rd_n ? 8'h00 : fmem(mem_addr);

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stimulus table: {addr, data}; expected pins equal the request
  localparam int NVEC = 6;
  localparam logic [23:0] WVEC [NVEC] = '{
    24'h0000_A5, 24'hFFFF_3C, 24'h0040_01, 24'h1234_FF, 24'h8001_00, 24'h7F7F_5A
  };

  // pin monitor
  int          rd_run = 0, wr_run = 0;
  int          rd_pulses = 0, rd_low_total = 0, wr_low_total = 0, ack_total = 0;
  logic [15:0] last_addr = '0;
  logic [15:0] exp_waddr = '0;
  logic [7:0]  exp_wdata = '0;
  logic        prev_wr_n = 1'b1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_rd_n && !mem_wr_n) chk(1'b0, "R11 both strobes low", 32'(mem_addr), 32'h0);
      if (!mem_rd_n) begin
        rd_low_total++;
        if (rd_run == 0) chk(mem_addr == 16'(32'h40 + rd_pulses), "R3 read address order",
                             32'(mem_addr), 32'h40 + 32'(rd_pulses));
        else chk(mem_addr == last_addr, "R4 address stable while low", 32'(mem_addr), 32'(last_addr));
        rd_run++;
      end else if (rd_run != 0) begin
        chk(rd_run == RD_N, "R4 read strobe width", 32'(rd_run), 32'(RD_N));
        chk(mem_addr == last_addr, "R4 address hold after rise", 32'(mem_addr), 32'(last_addr));
        rd_pulses++;
        rd_run = 0;
      end
      if (!mem_wr_n) begin
        wr_low_total++;
        wr_run++;
        chk(mem_addr == exp_waddr, "R9 write address", 32'(mem_addr), 32'(exp_waddr));
        chk(mem_wdata == exp_wdata, "R9 write data", 32'(mem_wdata), 32'(exp_wdata));
      end else if (!prev_wr_n) begin
        chk(wr_run == WR_N, "R9 write strobe width", 32'(wr_run), 32'(WR_N));
        chk(wr_ack == 1'b1, "R10 ack in cycle after write", 32'(wr_ack), 32'h1);
        wr_run = 0;
      end
      if (wr_ack) ack_total++;
      last_addr = mem_addr;
      prev_wr_n = mem_wr_n;
    end
  end

  task automatic do_write(input logic [15:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    exp_waddr = a; exp_wdata = d;
    wr_addr = a; wr_data = d; wr_req = 1'b1;
    repeat (hold) @(negedge clk);
    wr_req = 1'b0;
    for (int i = 0; i < 40 && !wr_ack; i++) @(negedge clk);
    chk(wr_ack == 1'b1, "R10 ack seen", 32'(wr_ack), 32'h1);
    @(negedge clk);
    chk(wr_ack == 1'b0, "R10 ack one cycle", 32'(wr_ack), 32'h0);
  endtask

  initial begin
    int base_wr, base_ack, base_rd;
    rst_n = 1'b0; strap_serial = 1'b0; wr_req = 1'b0;
    wr_addr = '0; wr_data = '0; cfg_rd_idx = 4'd5;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(mem_rd_n && mem_wr_n, "R1 strobes high in reset", {30'h0, mem_rd_n, mem_wr_n}, 32'h3);
    chk(!busy && !done && !wr_ack, "R1 flags low in reset", {29'h0, busy, done, wr_ack}, 32'h0);
    chk(cfg_rd_word == 32'h0, "R1 word cleared", cfg_rd_word, 32'h0);
    rst_n = 1'b1;

    // R8: request while busy
    for (int i = 0; i < 30 && !busy; i++) @(negedge clk);
    chk(busy == 1'b1, "R7 busy during preload", 32'(busy), 32'h1);
    repeat (5) @(negedge clk);
    wr_addr = 16'h2222; wr_data = 8'h99; wr_req = 1'b1;
    @(negedge clk);
    wr_req = 1'b0;
    for (int i = 0; i < 1000 && !done; i++) begin
      chk(!(busy && done), "R7 busy and done exclusive", {30'h0, busy, done}, 32'h2);
      @(negedge clk);
    end
    chk(done && !busy, "R7 done after preload", {30'h0, busy, done}, 32'h1);
    chk(rd_pulses == 64, "R3 read strobe count", 32'(rd_pulses), 32'd64);
    repeat (4) @(negedge clk);
    chk(wr_low_total == 0, "R8 request during busy dropped", 32'(wr_low_total), 32'h0);

    // R5 / R6: packed words
    for (int k = 0; k < 16; k++) begin
      logic [31:0] exp_w;
      for (int b = 0; b < 4; b++) exp_w[8*b +: 8] = fmem(16'(32'h40 + 4*k + b));
      cfg_rd_idx = 4'(k);
      #1;
      chk(cfg_rd_word == exp_w, "R6 packed word (R5 capture)", cfg_rd_word, exp_w);
    end

    // R9 / R10: table walk
    for (int v = 0; v < NVEC; v++) begin
      base_wr = wr_low_total;
      do_write(WVEC[v][23:8], WVEC[v][7:0], 1);
      chk(wr_low_total - base_wr == WR_N, "R9 one write per request",
          32'(wr_low_total - base_wr), 32'(WR_N));
    end

    // R10: request held during write starts no second write
    base_wr = wr_low_total;
    do_write(16'h0BAD, 8'hC3, 3);
    repeat (6) @(negedge clk);
    chk(wr_low_total - base_wr == WR_N, "R10 held request ignored",
        32'(wr_low_total - base_wr), 32'(WR_N));
    chk(done == 1'b1, "R7 done sticky", 32'(done), 32'h1);

    // R2: serial strap
    @(negedge clk);
    rst_n = 1'b0; strap_serial = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    base_rd = rd_low_total; base_wr = wr_low_total; base_ack = ack_total;
    repeat (60) @(negedge clk);
    wr_addr = 16'h0050; wr_data = 8'h11; wr_req = 1'b1;
    repeat (3) @(negedge clk);
    wr_req = 1'b0;
    repeat (20) @(negedge clk);
    chk(rd_low_total == base_rd, "R2 no read strobe", 32'(rd_low_total - base_rd), 32'h0);
    chk(!busy && !done, "R2 flags low", {30'h0, busy, done}, 32'h0);
    chk(wr_low_total == base_wr && ack_total == base_ack, "R2 write ignored",
        32'(wr_low_total - base_wr), 32'h0);
    cfg_rd_idx = 4'd0;
    #1;
    chk(cfg_rd_word == 32'h0, "R2 bank untouched", cfg_rd_word, 32'h0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule